// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block receives serial digital audio in slave mode and turns it into parallel samples, each tagged with a channel number from 0 to 5. The bit clock, the word clock and three data lines come from an external source. A faster system clock oversamples them through synchronizers, and every action happens on a detected bit-clock rising edge. A 3-bit format code selects I2S, left-justified, right-justified, or one of two time-multiplexed frame-sync modes that differ only in where the first bit falls. A 2-bit code selects the word length.

In the three stereo formats, each data line carries one left/right pair. All three lines finish a word on the same bit-clock edge. A small serializer then emits those words one per system cycle. In the two frame-sync modes, six words arrive back to back on data line 0 after each word-clock rising edge. The slot index is the channel number. Samples are always left-aligned in a 32-bit word. A format and length pair that is not allowed raises an error flag and blocks all output strobes.

Top module: `audio_rx`

## Requirements
- R1: `fmt_i` codes: 0 = I2S, 1 = left-justified, 2 = right-justified, 3 = frame-sync early, 4 = frame-sync late. `wlen_i` codes: 0/1/2/3 = 16/20/24/32 bits. All words are sent MSB first.
- R2: Every sample on `sample_o` is left-aligned. The N received bits occupy bits 31 down to 32-N, and the lower bits are zero.
- R3: Left-justified: the MSB is sampled on the first bit-clock rise after a word-clock change, and word-clock high means left. Data line k produces channel 2k for left and 2k+1 for right.
- R4: I2S: the MSB is sampled on the second bit-clock rise after a word-clock change, and word-clock low means left. Each half-frame holds at least N+1 bit clocks.
- R5: Right-justified: the last N bits before a word-clock change form the word, with the LSB on the final rise. The word is emitted once the change is seen, tagged with the channel of the half that just ended (high = left).
- R6: Frame-sync early: the MSB of slot 0 is sampled on the rise where the word clock is first seen high. Six N-bit slots follow on data line 0 as channels 0 to 5. Data lines 1 and 2 have no effect in this mode.
- R7: Frame-sync late: identical to R6, except that the MSB of slot 0 is sampled one bit clock after the rise where the word clock is first seen high.
- R8: Format codes 5 to 7, and right-justified with 32-bit words, drive `err_o` high from the next system cycle. While `err_o` is high, `valid_o` stays low.
- R9: When three words complete on the same bit-clock edge, they all appear on `valid_o`, one per system cycle, in data-line order 0, 1, 2. This holds for any bit-clock period of at least 8 system clocks.
- R10: While reset is asserted, `valid_o`, `err_o`, `chan_o` and `sample_o` are all zero.
- R11: After reset, no word is produced from the bits before the first observed word-clock change in the stereo formats, or before the first word-clock rising edge in the frame-sync modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 3 | Framing format code |
| wlen_i | input | 2 | Word length code |
| bclk_i | input | 1 | Serial bit clock |
| lrclk_i | input | 1 | Word clock / frame sync |
| din_i | input | 3 | Serial data lines |
| valid_o | output | 1 | Sample strobe, one system cycle |
| chan_o | output | 3 | Channel tag, 0 to 5 |
| sample_o | output | 32 | Left-aligned sample |
| err_o | output | 1 | Illegal format/length pair |

## Verification
In the stereo formats, all three data lines finish a word on the same bit-clock rise. The three completions therefore land in one system cycle, and the serializer must drain them in order without losing any. Every stereo test provokes this collision, because the three lines always share their framing. Each test then compares the full ordered list of captured (channel, sample) pairs with the list the bench builds from its own bit streams. A dropped word, a duplicate or a swapped order each show up as a count or order mismatch.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;
  localparam int SAMPLE_W = 32;

  typedef enum logic [2:0] {
    FMT_I2S   = 3'd0,
    FMT_LJ    = 3'd1,
    FMT_RJ    = 3'd2,
    FMT_DSP_E = 3'd3,
    FMT_DSP_L = 3'd4
  } fmt_e;

  function automatic logic [5:0] wlen_bits(input logic [1:0] w);
    case (w)
      2'd0:    return 6'd16;
      2'd1:    return 6'd20;
      2'd2:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic [SAMPLE_W-1:0] align_left(input logic [SAMPLE_W-1:0] sr,
                                                     input logic [1:0] w);
    case (w)
      2'd0:    return {sr[15:0], 16'b0};
      2'd1:    return {sr[19:0], 12'b0};
      2'd2:    return {sr[23:0], 8'b0};
      default: return sr;
    endcase
  endfunction

  function automatic logic illegal_cfg(input logic [2:0] f, input logic [1:0] w);
    return (f > 3'd4) || (f == FMT_RJ && w == 2'd3);
  endfunction
endpackage

// File: rtl/audio_rx_sync.sv
module audio_rx_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/audio_rx_lane.sv
module audio_rx_lane
  import audio_rx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                rise_i,
  input  logic                lr_i,
  input  logic                din_i,
  input  logic [2:0]          fmt_i,
  input  logic [1:0]          wlen_i,
  output logic                done_o,
  output logic                right_o,
  output logic [SAMPLE_W-1:0] word_o
);
  logic [SAMPLE_W-1:0] sr_q, sr_n, src;
  logic [5:0] cnt_q, cnt_n, n;
  logic lr_q, have_q, synced_q;
  logic lr_edge, synced_n, hit, rgt;

  always_comb begin
    n        = wlen_bits(wlen_i);
    lr_edge  = have_q && (lr_i != lr_q);
    synced_n = synced_q | lr_edge;
    sr_n     = {sr_q[SAMPLE_W-2:0], din_i};
    cnt_n    = lr_edge ? 6'd1 : ((cnt_q == 6'd63) ? cnt_q : cnt_q + 6'd1);
    hit = 1'b0;
    src = sr_n;
    rgt = 1'b0;
    case (fmt_i)
      FMT_LJ: begin
        hit = synced_n && (cnt_n == n);
        rgt = !lr_i;
      end
      FMT_I2S: begin
        hit = synced_n && (cnt_n == n + 6'd1);
        rgt = lr_i;
      end
      FMT_RJ: begin
        // word of the half that just closed
        hit = lr_edge && synced_q && (cnt_q >= n);
        src = sr_q;
        rgt = !lr_q;
      end
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q     <= '0;
      cnt_q    <= '0;
      lr_q     <= 1'b0;
      have_q   <= 1'b0;
      synced_q <= 1'b0;
      done_o   <= 1'b0;
      right_o  <= 1'b0;
      word_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (!en_i) begin
        have_q   <= 1'b0;
        synced_q <= 1'b0;
      end else if (rise_i) begin
        sr_q     <= sr_n;
        cnt_q    <= cnt_n;
        lr_q     <= lr_i;
        have_q   <= 1'b1;
        synced_q <= synced_n;
        if (hit) begin
          done_o  <= 1'b1;
          right_o <= rgt;
          word_o  <= align_left(src, wlen_i);
        end
      end
    end
  end
endmodule

// File: rtl/audio_rx_tdm.sv
module audio_rx_tdm
  import audio_rx_pkg::*;
#(
  parameter int SLOTS = 6,
  parameter int CH_W  = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                rise_i,
  input  logic                lr_i,
  input  logic                din_i,
  input  logic                late_i,
  input  logic [1:0]          wlen_i,
  output logic                done_o,
  output logic [CH_W-1:0]     slot_o,
  output logic [SAMPLE_W-1:0] word_o
);
  logic [SAMPLE_W-1:0] sr_q, sr_n;
  logic [5:0] idx_q, cur, n;
  logic [CH_W-1:0] slot_q, slot_c;
  logic lr_q, have_q, arm_q, act_q;
  logic sync_e, start, run, last;

  always_comb begin
    n      = wlen_bits(wlen_i);
    sync_e = have_q && lr_i && !lr_q;
    start  = late_i ? arm_q : sync_e;
    run    = start || act_q;
    cur    = start ? 6'd0 : idx_q;
    slot_c = start ? '0 : slot_q;
    last   = run && (cur == n - 6'd1);
    sr_n   = {sr_q[SAMPLE_W-2:0], din_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      idx_q  <= '0;
      slot_q <= '0;
      lr_q   <= 1'b0;
      have_q <= 1'b0;
      arm_q  <= 1'b0;
      act_q  <= 1'b0;
      done_o <= 1'b0;
      slot_o <= '0;
      word_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (!en_i) begin
        have_q <= 1'b0;
        arm_q  <= 1'b0;
        act_q  <= 1'b0;
      end else if (rise_i) begin
        sr_q   <= sr_n;
        lr_q   <= lr_i;
        have_q <= 1'b1;
        arm_q  <= late_i && sync_e;
        if (run) begin
          idx_q  <= last ? 6'd0 : cur + 6'd1;
          act_q  <= !(last && slot_c == CH_W'(SLOTS - 1));
          slot_q <= last ? slot_c + 1'b1 : slot_c;
          if (last) begin
            done_o <= 1'b1;
            slot_o <= slot_c;
            word_o <= align_left(sr_n, wlen_i);
          end
        end
      end
    end
  end
endmodule

// File: rtl/audio_rx.sv
module audio_rx
  import audio_rx_pkg::*;
#(
  parameter  int LANES       = 3,
  parameter  int SYNC_STAGES = 2,
  localparam int CH_W        = $clog2(2 * LANES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2:0]          fmt_i,
  input  logic [1:0]          wlen_i,
  input  logic                bclk_i,
  input  logic                lrclk_i,
  input  logic [LANES-1:0]    din_i,
  output logic                valid_o,
  output logic [CH_W-1:0]     chan_o,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                err_o
);
  localparam int SW = LANES + 2;

  logic [SW-1:0] s_vec;
  logic [LANES-1:0] s_din;
  logic s_bclk, s_lr, bclk_q, rise, err_q, st_en, tdm_en;

  audio_rx_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i({lrclk_i, bclk_i, din_i}), .q_o(s_vec)
  );

  assign s_din  = s_vec[LANES-1:0];
  assign s_bclk = s_vec[LANES];
  assign s_lr   = s_vec[LANES+1];
  assign rise   = s_bclk & ~bclk_q;
  assign st_en  = !err_q && (fmt_i <= FMT_RJ);
  assign tdm_en = !err_q && (fmt_i == FMT_DSP_E || fmt_i == FMT_DSP_L);
  assign err_o  = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      bclk_q <= s_bclk;
      err_q  <= illegal_cfg(fmt_i, wlen_i);
    end
  end

  logic [LANES-1:0] lane_done, lane_rgt;
  logic [SAMPLE_W-1:0] lane_word [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    audio_rx_lane u_lane (
      .clk_i, .rst_ni,
      .en_i   (st_en),
      .rise_i (rise),
      .lr_i   (s_lr),
      .din_i  (s_din[g]),
      .fmt_i,
      .wlen_i,
      .done_o (lane_done[g]),
      .right_o(lane_rgt[g]),
      .word_o (lane_word[g])
    );
  end

  logic tdm_done;
  logic [CH_W-1:0] tdm_slot;
  logic [SAMPLE_W-1:0] tdm_word;

  audio_rx_tdm #(.SLOTS(2 * LANES), .CH_W(CH_W)) u_tdm (
    .clk_i, .rst_ni,
    .en_i   (tdm_en),
    .rise_i (rise),
    .lr_i   (s_lr),
    .din_i  (s_din[0]),
    .late_i (fmt_i == FMT_DSP_L),
    .wlen_i,
    .done_o (tdm_done),
    .slot_o (tdm_slot),
    .word_o (tdm_word)
  );

  // serializer for lanes that finish together
  logic [LANES-1:0] pend_q, rgt_q;
  logic [SAMPLE_W-1:0] hold_q [LANES];
  logic pick_v, pick_rgt;
  logic [CH_W-1:0] pick;
  logic [SAMPLE_W-1:0] pick_word;

  always_comb begin
    pick_v    = 1'b0;
    pick      = '0;
    pick_rgt  = 1'b0;
    pick_word = '0;
    for (int l = LANES - 1; l >= 0; l--) begin
      if (pend_q[l]) begin
        pick_v    = 1'b1;
        pick      = CH_W'(l);
        pick_rgt  = rgt_q[l];
        pick_word = hold_q[l];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      rgt_q    <= '0;
      for (int l = 0; l < LANES; l++) hold_q[l] <= '0;
      valid_o  <= 1'b0;
      chan_o   <= '0;
      sample_o <= '0;
    end else begin
      valid_o <= 1'b0;
      for (int l = 0; l < LANES; l++) begin
        if (lane_done[l]) begin
          pend_q[l] <= 1'b1;
          rgt_q[l]  <= lane_rgt[l];
          hold_q[l] <= lane_word[l];
        end else if (pick_v && pick == CH_W'(l)) begin
          pend_q[l] <= 1'b0;
        end
      end
      if (tdm_done) begin
        valid_o  <= 1'b1;
        chan_o   <= tdm_slot;
        sample_o <= tdm_word;
      end else if (pick_v) begin
        valid_o  <= 1'b1;
        chan_o   <= CH_W'(2 * pick) + CH_W'(pick_rgt);
        sample_o <= pick_word;
      end
    end
  end
endmodule

// File: rtl/audio_rx_checker.sv
module audio_rx_checker
  import audio_rx_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic [2:0]          fmt_i,
  input logic [1:0]          wlen_i,
  input logic                valid_o,
  input logic [2:0]          chan_o,
  input logic [SAMPLE_W-1:0] sample_o,
  input logic                err_o
);
  logic [SAMPLE_W-1:0] low_mask;
  logic bad_cfg;

  always_comb begin
    case (wlen_i)
      2'd0:    low_mask = 32'h0000_FFFF;
      2'd1:    low_mask = 32'h0000_0FFF;
      2'd2:    low_mask = 32'h0000_00FF;
      default: low_mask = 32'h0;
    endcase
    bad_cfg = (fmt_i > 3'd4) || (fmt_i == 3'd2 && wlen_i == 2'd3);
  end

  a_r8_no_strobe_on_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !valid_o);

  a_r1_chan_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> chan_o < 3'd6);

  a_r2_left_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (sample_o & low_mask) == '0);

  a_r8_err_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_cfg |=> err_o);

  a_r8_err_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad_cfg |=> !err_o);
endmodule

bind audio_rx audio_rx_checker u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .fmt_i   (fmt_i),
  .wlen_i  (wlen_i),
  .valid_o (valid_o),
  .chan_o  (chan_o),
  .sample_o(sample_o),
  .err_o   (err_o)
);

// File: tb/audio_rx_bench.sv
module audio_rx_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [2:0] fmt = '0;
  logic [1:0] wlen = '0;
  logic bclk = 1'b0, lrclk = 1'b0;
  logic [2:0] din = '0;
  logic valid;
  logic [2:0] chan;
  logic [31:0] sample;
  logic err;

  audio_rx u_audio_rx (
    .clk_i(clk), .rst_ni(rst_n), .fmt_i(fmt), .wlen_i(wlen),
    .bclk_i(bclk), .lrclk_i(lrclk), .din_i(din),
    .valid_o(valid), .chan_o(chan), .sample_o(sample), .err_o(err)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [2:0]  exp_ch [64];
  logic [31:0] exp_s  [64];
  logic [2:0]  got_ch [64];
  logic [31:0] got_s  [64];
  int exp_n = 0, got_n = 0;

  always @(negedge clk)
    if (rst_n && valid) begin
      if (got_n < 64) begin
        got_ch[got_n] = chan;
        got_s[got_n]  = sample;
      end
      got_n++;
    end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nbits(input logic [1:0] w);
    return (w == 2'd0) ? 16 : (w == 2'd1) ? 20 : (w == 2'd2) ? 24 : 32;
  endfunction

  function automatic logic [31:0] rnd_word(input int n);
    logic [31:0] m = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    return $urandom & m;
  endfunction

  function automatic logic [31:0] lalign(input logic [31:0] w, input int n);
    return w << (32 - n);
  endfunction

  function automatic logic bit_of(input logic [31:0] w, input int i);
    return (i >= 0 && i < 32) ? w[i] : 1'b0;
  endfunction

  task automatic push_exp(input logic [2:0] c, input logic [31:0] s);
    if (exp_n < 64) begin
      exp_ch[exp_n] = c;
      exp_s[exp_n]  = s;
    end
    exp_n++;
  endtask

  task automatic bcyc(input logic lr, input logic [2:0] d);
    @(negedge clk);
    bclk = 1'b0; lrclk = lr; din = d;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset(input logic [2:0] f, input logic [1:0] w, input bit check_rst);
    @(negedge clk);
    rst_n = 1'b0; fmt = f; wlen = w; bclk = 0; lrclk = 0; din = 0;
    repeat (3) @(negedge clk);
    if (check_rst) begin
      chk(valid == 0 && err == 0, "R10 reset valid/err", {30'b0, valid, err}, 32'h0);
      chk(sample == 0 && chan == 0, "R10 reset sample/chan", sample | {29'b0, chan}, 32'h0);
    end
    rst_n = 1'b1;
    exp_n = 0; got_n = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic compare(input string req);
    repeat (24) @(negedge clk);
    chk(got_n == exp_n, {req, " count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n && i < 64; i++) begin
      chk(got_ch[i] == exp_ch[i], {req, " chan"}, {29'b0, got_ch[i]}, {29'b0, exp_ch[i]});
      chk(got_s[i] == exp_s[i], {req, " sample"}, got_s[i], exp_s[i]);
    end
  endtask

  // stereo formats: 0 I2S, 1 LJ, 2 RJ
  task automatic run_stereo(input logic [2:0] f, input logic [1:0] w, input int frames,
                            input int extra, input bit expect_out);
    int n = nbits(w);
    int h = n + ((f == 3'd0) ? 1 : 0) + extra;
    logic left_lvl = (f == 3'd0) ? 1'b0 : 1'b1;
    logic lvl = left_lvl;
    logic [31:0] wd [3];
    // prelude at the opposite level: must yield nothing (R11)
    for (int k = 0; k < 3; k++) bcyc(~left_lvl, 3'($urandom));
    for (int hh = 0; hh < 2 * frames; hh++) begin
      logic rgt = hh[0];
      lvl = rgt ? ~left_lvl : left_lvl;
      for (int l = 0; l < 3; l++) begin
        wd[l] = rnd_word(n);
        if (expect_out) push_exp(3'(2 * l + int'(rgt)), lalign(wd[l], n));
      end
      for (int k = 1; k <= h; k++) begin
        logic [2:0] d;
        for (int l = 0; l < 3; l++) begin
          if (f == 3'd1)      d[l] = (k <= n) ? bit_of(wd[l], n - k) : 1'b0;
          else if (f == 3'd0) d[l] = (k >= 2 && k <= n + 1) ? bit_of(wd[l], n - k + 1) : 1'b0;
          else                d[l] = (k - (h - n) >= 1) ? bit_of(wd[l], n - (k - (h - n))) : 1'b0;
        end
        bcyc(lvl, d);
      end
    end
    for (int k = 0; k < 3; k++) bcyc(~lvl, 3'b000);
  endtask

  task automatic run_tdm(input bit late, input logic [1:0] w, input int frames);
    int n = nbits(w);
    int t = 6 * n + (late ? 1 : 0) + 2;
    logic [31:0] wd [6];
    for (int k = 0; k < 3; k++) bcyc(1'b0, 3'($urandom));
    for (int fr = 0; fr < frames; fr++) begin
      for (int s = 0; s < 6; s++) begin
        wd[s] = rnd_word(n);
        push_exp(3'(s), lalign(wd[s], n));
      end
      for (int j = 0; j < t; j++) begin
        int b = late ? j - 1 : j;
        logic bt = (b >= 0 && b < 6 * n) ? bit_of(wd[b / n], n - 1 - (b % n)) : 1'b0;
        // lines 1 and 2 carry noise that must be ignored (R6)
        bcyc(j == 0, {2'($urandom), bt});
      end
    end
    for (int k = 0; k < 3; k++) bcyc(1'b0, 3'b000);
  endtask

  initial begin
    void'($urandom(32'h5EED_0A11));
    do_reset(3'd1, 2'd0, 1'b1);
    // directed: each length in left-justified with minimal halves
    for (int w = 0; w < 4; w++) begin
      do_reset(3'd1, 2'(w), 1'b0);
      run_stereo(3'd1, 2'(w), 2, 0, 1'b1);
      compare("R3 R9 R11 left-justified");
    end
    do_reset(3'd0, 2'd3, 1'b0);
    run_stereo(3'd0, 2'd3, 2, 0, 1'b1);
    compare("R4 R9 i2s 32-bit");
    do_reset(3'd2, 2'd0, 1'b0);
    run_stereo(3'd2, 2'd0, 2, 0, 1'b1);
    compare("R5 right-justified tight half");
    do_reset(3'd3, 2'd0, 1'b0);
    run_tdm(1'b0, 2'd0, 2);
    compare("R6 frame-sync early");
    do_reset(3'd4, 2'd3, 1'b0);
    run_tdm(1'b1, 2'd3, 1);
    compare("R7 frame-sync late");
    // random legal configurations
    for (int it = 0; it < 8; it++) begin
      logic [2:0] f = 3'($urandom % 5);
      logic [1:0] w = 2'($urandom % 4);
      if (f == 3'd2 && w == 2'd3) w = 2'd2;
      do_reset(f, w, 1'b0);
      if (f <= 3'd2) begin
        run_stereo(f, w, 1 + ($urandom % 2), $urandom % 5, 1'b1);
        compare("R1 R2 R9 random stereo");
      end else begin
        run_tdm(f == 3'd4, w, 1);
        compare("R1 R6 R7 random frame-sync");
      end
      chk(err == 0, "R8 legal config no error", {31'b0, err}, 32'h0);
    end
    // illegal pairs
    do_reset(3'd2, 2'd3, 1'b0);
    run_stereo(3'd2, 2'd3, 1, 0, 1'b0);
    compare("R8 right-justified 32-bit");
    chk(err == 1, "R8 error flag rj32", {31'b0, err}, 32'h1);
    do_reset(3'd5, 2'd0, 1'b0);
    run_stereo(3'd1, 2'd0, 1, 0, 1'b0);
    compare("R8 format code 5");
    chk(err == 1, "R8 error flag code 5", {31'b0, err}, 32'h1);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule